// File: doc/BRIEF.md
# General-Purpose Timer Core

This block is a free-running up-counter with a small register file, used by software for delays, periodic ticks, event timestamping and simple waveform generation. The counter advances on every clock, or on a tick taken from a power-of-two prescaler. When it passes its all-ones value it either reloads from a load register and keeps running, or it wraps to zero and stops itself. A compare register raises a match event when the counter steps onto its value. A capture input latches the counter on a chosen edge. A PWM pin pulses or toggles on overflow, or on overflow or match, from a programmable idle level.

Software reaches the block through a plain single-cycle register port. Every write is accepted in the cycle it is presented and takes effect at that clock edge. Read data is a combinational function of the address. The port has no handshake and never stalls. Status flags for match, overflow and capture are cleared by writing ones. One interrupt line combines the flags with their enable bits.

Top module: `gpt_timer_core`

## Requirements
- R1: Control bit 0 (offset 0x24) runs the counter (offset 0x28) when set; while it is clear the counter holds its value unless software writes it.
- R2: With control bit 1 set, a tick taken at the all-ones count reloads the counter from the load register (offset 0x2C) and sets status bit 1.
- R3: With control bit 1 clear, a tick at the all-ones count wraps the counter to zero, sets status bit 1 and clears control bit 0 in the same edge.
- R4: With control bit 5 clear, the counter advances once per clock while running. With it set, it advances once per 2^(v+1) clocks, where v is control bits 4:2; the divider restarts from zero when the counter is started.
- R5: With control bit 6 set, a tick that moves the counter onto the match register value (offset 0x38) sets status bit 0; with bit 6 clear it never does.
- R6: Status (offset 0x18) holds match in bit 0, overflow in bit 1 and capture in bit 2. Writing 1 to a bit clears it, writing 0 leaves it, and a new event wins over a clear in the same cycle. irq is high when any status bit is set together with the same bit of the enable register (offset 0x1C).
- R7: A write of any value to the trigger offset 0x30 copies the load register into the counter; a write to offset 0x28 sets the counter directly.
- R8: cap_in passes through a two-flop synchroniser. Control bits 9:8 choose the capture edge: 0 off, 1 rising, 2 falling, 3 both. On a selected edge the counter is copied to the capture register (offset 0x3C, read-only) and status bit 2 is set; edges that are not selected have no effect.
- R9: Control bits 11:10 choose the PWM trigger: 0 none, 1 overflow, 2 overflow or match, 3 none. With no trigger events, pwm_out equals control bit 7.
- R10: With control bit 12 clear (pulse), pwm_out takes the inverse of bit 7 from a trigger event until the next tick or until the counter stops. With bit 12 set (toggle), pwm_out inverts on every trigger event; clearing bit 12 returns it to bit 7.
- R11: After reset all registers read zero, pwm_out and irq are low. Control keeps bits 12:0 of a write; other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the counter's sequencing. The counter holds while stopped, ticks exist only while running, and an overflow reloads or stops according to the mode. A trigger write loads the counter, and a compare hit raises the match flag. Other behaviour only the bench scenarios can show. These are the exact prescaled periods across all eight divider settings, the edge selection behind the synchroniser, and the write-one-to-clear masking of irq. They also cover the PWM waveforms, computed cycle by cycle for each trigger, idle level and pulse or toggle choice.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_IEN   = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_CNT   = 8'h28;
  localparam logic [REG_AW-1:0] OFS_LOAD  = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_TRIG  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_MATCH = 8'h38;
  localparam logic [REG_AW-1:0] OFS_CAPT  = 8'h3C;

  // control field positions
  localparam int CB_RUN     = 0;
  localparam int CB_AUTO    = 1;
  localparam int CB_PVAL_LO = 2;
  localparam int PVAL_W     = 3;
  localparam int CB_PRE     = 5;
  localparam int CB_CMP     = 6;
  localparam int CB_DEF     = 7;
  localparam int CB_EDGE_LO = 8;
  localparam int CB_TRIG_LO = 10;
  localparam int CB_TOG     = 12;
  localparam int CTRL_W     = 13;

  // status bit positions
  localparam int SB_MATCH = 0;
  localparam int SB_OVF   = 1;
  localparam int SB_CAP   = 2;
  localparam int STAT_W   = 3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    PT_NONE      = 2'd0,
    PT_OVF       = 2'd1,
    PT_OVF_MATCH = 2'd2,
    PT_RSVD      = 2'd3
  } pwm_trig_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PV_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pre_en,
  input  logic [PV_W-1:0] pre_val,
  output logic            tick
);
  localparam int DIV_W = 1 << PV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   span;

  // span = 2^(pre_val+1), held one bit wider so the largest setting fits
  assign span = (DIV_W+1)'(1) << ({1'b0, pre_val} + (PV_W+1)'(1));
  assign lim  = DIV_W'(span - (DIV_W+1)'(1));
  assign tick = run & (~pre_en | (div_q == lim));

  always_ff @(posedge clk) begin
    if (!rst_n)                div_q <= '0;
    else if (!run || !pre_en)  div_q <= '0;
    else if (div_q == lim)     div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gpt_edge_detect.sv
module gpt_edge_detect
  import gpt_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_in,
  input  edge_mode_e mode,
  output logic       hit
);
  logic [SYNC:0] sh_q;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], sig_in};
  end

  assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall = ~sh_q[SYNC-1] & sh_q[SYNC];

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpt_pwm_gen.sv
module gpt_pwm_gen
  import gpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      ovf_evt,
  input  logic      match_evt,
  input  logic      def_lvl,
  input  logic      toggle_mode,
  input  pwm_trig_e trig_sel,
  output logic      pwm_out
);
  logic fire;
  logic pulse_q, tog_q;

  always_comb begin
    unique case (trig_sel)
      PT_OVF:       fire = ovf_evt;
      PT_OVF_MATCH: fire = ovf_evt | match_evt;
      default:      fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (fire)              pulse_q <= 1'b1;
      else if (tick || !run) pulse_q <= 1'b0;
      if (!toggle_mode)      tog_q <= 1'b0;
      else if (fire)         tog_q <= ~tog_q;
    end
  end

  assign pwm_out = def_lvl ^ (toggle_mode ? tog_q : pulse_q);
endmodule

// File: rtl/gpt_timer_core.sv
module gpt_timer_core
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, load_q, match_q, capt_q;
  logic [STAT_W-1:0] stat_q, ien_q, stat_set, stat_clr;

  logic ctrl_wr, cnt_wr, load_wr, trg_wr, match_wr, stat_wr, ien_wr;
  logic tick, adv, at_top, ovf_evt, match_evt, cap_hit;
  logic [CNT_W-1:0] adv_val;

  assign ctrl_wr  = reg_wr & (reg_addr == OFS_CTRL);
  assign cnt_wr   = reg_wr & (reg_addr == OFS_CNT);
  assign load_wr  = reg_wr & (reg_addr == OFS_LOAD);
  assign trg_wr   = reg_wr & (reg_addr == OFS_TRIG);
  assign match_wr = reg_wr & (reg_addr == OFS_MATCH);
  assign stat_wr  = reg_wr & (reg_addr == OFS_STAT);
  assign ien_wr   = reg_wr & (reg_addr == OFS_IEN);

  gpt_prescaler #(.PV_W(PVAL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[CB_RUN]),
    .pre_en  (ctrl_q[CB_PRE]),
    .pre_val (ctrl_q[CB_PVAL_LO +: PVAL_W]),
    .tick    (tick)
  );

  // software writes take priority over counting
  assign adv       = tick & ~cnt_wr & ~trg_wr;
  assign at_top    = &cnt_q;
  assign ovf_evt   = adv & at_top;
  assign adv_val   = at_top ? (ctrl_q[CB_AUTO] ? load_q : '0) : cnt_q + 1'b1;
  assign match_evt = adv & ctrl_q[CB_CMP] & (adv_val == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= reg_wdata;
    else if (trg_wr) cnt_q <= load_q;
    else if (adv)    cnt_q <= adv_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else begin
      if (ctrl_wr)                              ctrl_q <= reg_wdata[CTRL_W-1:0];
      else if (ovf_evt && !ctrl_q[CB_AUTO])     ctrl_q[CB_RUN] <= 1'b0;
      if (load_wr)  load_q  <= reg_wdata;
      if (match_wr) match_q <= reg_wdata;
      if (ien_wr)   ien_q   <= reg_wdata[STAT_W-1:0];
    end
  end

  gpt_edge_detect #(.SYNC(SYNC_STAGES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (cap_in),
    .mode   (edge_mode_e'(ctrl_q[CB_EDGE_LO +: 2])),
    .hit    (cap_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       capt_q <= '0;
    else if (cap_hit) capt_q <= cnt_q;
  end

  always_comb begin
    stat_set           = '0;
    stat_set[SB_MATCH] = match_evt;
    stat_set[SB_OVF]   = ovf_evt;
    stat_set[SB_CAP]   = cap_hit;
    stat_clr           = stat_wr ? reg_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  assign irq = |(stat_q & ien_q);

  gpt_pwm_gen u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (ctrl_q[CB_RUN]),
    .tick        (tick),
    .ovf_evt     (ovf_evt),
    .match_evt   (match_evt),
    .def_lvl     (ctrl_q[CB_DEF]),
    .toggle_mode (ctrl_q[CB_TOG]),
    .trig_sel    (pwm_trig_e'(ctrl_q[CB_TRIG_LO +: 2])),
    .pwm_out     (pwm_out)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      OFS_CNT:   reg_rdata = cnt_q;
      OFS_LOAD:  reg_rdata = load_q;
      OFS_MATCH: reg_rdata = match_q;
      OFS_CAPT:  reg_rdata = capt_q;
      OFS_STAT:  reg_rdata = CNT_W'(stat_q);
      OFS_IEN:   reg_rdata = CNT_W'(ien_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpt_timer_core_chk.sv
module gpt_timer_core_chk
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  match_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              tick,
  input logic              cnt_wr,
  input logic              trg_wr,
  input logic              ctrl_wr
);
  p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_RUN] && !cnt_wr && !trg_wr) |=> $stable(cnt_q));

  p_reload_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q) && ctrl_q[CB_AUTO] && !cnt_wr && !trg_wr)
      |=> (cnt_q == $past(load_q)));

  p_oneshot_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q) && !ctrl_q[CB_AUTO] && !cnt_wr && !trg_wr && !ctrl_wr)
      |=> (cnt_q == '0 && !ctrl_q[CB_RUN]));

  p_tick_only_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_q[CB_RUN]);

  p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[CB_CMP] && !(&cnt_q) && ((cnt_q + 1'b1) == match_q)
     && !cnt_wr && !trg_wr) |=> stat_q[SB_MATCH]);

  p_trigger_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_wr && !cnt_wr) |=> (cnt_q == $past(load_q)));
endmodule

bind gpt_timer_core gpt_timer_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_q  (ctrl_q),
  .cnt_q   (cnt_q),
  .load_q  (load_q),
  .match_q (match_q),
  .stat_q  (stat_q),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .trg_wr  (trg_wr),
  .ctrl_wr (ctrl_wr)
);

// File: tb/gpt_timer_core_tb_top.sv
`timescale 1ns/1ps
module gpt_timer_core_tb_top;
  localparam logic [7:0] A_STAT = 8'h18, A_IEN = 8'h1C, A_CTRL = 8'h24, A_CNT = 8'h28,
                         A_LOAD = 8'h2C, A_TRIG = 8'h30, A_MATCH = 8'h38, A_CAPT = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpt_timer_core dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pwm_case(input bit def, input bit tog, input logic [1:0] trig, input string tag);
    int par;
    logic [31:0] c;
    bit ev;
    bit exp;
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'hFFFF_FFFC);
    wr(A_CNT, 32'hFFFF_FFFC);
    wr(A_MATCH, 32'hFFFF_FFFD);
    wr(A_CTRL, 32'h3 | (32'(def) << 7) | (32'h1 << 6) | (32'(trig) << 10) | (32'(tog) << 12));
    par = 0;
    for (int m = 0; m < 10; m++) begin
      c  = 32'hFFFF_FFFC + 32'(m % 4);
      ev = 1'b0;
      if (m > 0 && (trig == 2'd1 || trig == 2'd2) && (m % 4 == 0)) ev = 1'b1;
      if (m > 0 && trig == 2'd2 && c == 32'hFFFF_FFFD) ev = 1'b1;
      if (ev) par ^= 1;
      exp = def ^ (tog ? par[0] : ev);
      #1;
      check(tag, 32'(pwm_out), 32'(exp));
      @(negedge clk);
    end
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, held;
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);

    // R11 reset state
    rd(A_CTRL, v);  check("R11 ctrl reset", v, 0);
    rd(A_CNT, v);   check("R11 cnt reset", v, 0);
    rd(A_LOAD, v);  check("R11 load reset", v, 0);
    rd(A_MATCH, v); check("R11 match reset", v, 0);
    rd(A_CAPT, v);  check("R11 capt reset", v, 0);
    rd(A_STAT, v);  check("R11 stat reset", v, 0);
    rd(A_IEN, v);   check("R11 ien reset", v, 0);
    check("R11 pwm reset", 32'(pwm_out), 0);
    check("R11 irq reset", 32'(irq), 0);

    // R11 readback, upper ctrl bits dropped
    wr(A_CTRL, 32'hFFFF_1AFC);
    rd(A_CTRL, v); check("R11 ctrl width", v, 32'h1AFC);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'hCAFE_0001);
    rd(A_LOAD, v); check("R11 load readback", v, 32'hCAFE_0001);
    rd(8'h40, v);  check("R11 unmapped offset", v, 0);

    // R7 trigger and direct write
    wr(A_LOAD, 32'h0000_1234);
    wr(A_TRIG, 32'hDEAD_BEEF);
    rd(A_CNT, v); check("R7 trigger load", v, 32'h1234);
    wr(A_CNT, 32'h42);
    rd(A_CNT, v); check("R7 direct write", v, 32'h42);

    // R1 run one per clock, then hold
    wr(A_CNT, 32'd10);
    wr(A_CTRL, 32'h1);
    wait_neg(7);
    rd(A_CNT, v); check("R1 running count", v, 32'd17);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, held);
    wait_neg(5);
    rd(A_CNT, v); check("R1 hold when stopped", v, held);

    // R4 prescaler sweep over every setting
    for (int pv = 0; pv < 8; pv++) begin
      int d;
      d = 2 << pv;
      wr(A_CNT, 32'h0);
      wr(A_CTRL, 32'h1 | 32'h20 | (32'(pv) << 2));
      wait_neg(d - 1);
      rd(A_CNT, v); check($sformatf("R4 prescale %0d before", pv), v, 0);
      wait_neg(1);
      rd(A_CNT, v); check($sformatf("R4 prescale %0d step", pv), v, 1);
      wait_neg(2 * d);
      rd(A_CNT, v); check($sformatf("R4 prescale %0d third", pv), v, 3);
      wr(A_CTRL, 32'h0);
    end

    // R2 auto-reload
    wr(A_STAT, 32'h7);
    wr(A_LOAD, 32'h100);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h3);
    wait_neg(2);
    rd(A_CNT, v);  check("R2 reload value", v, 32'h100);
    rd(A_STAT, v); check("R2 overflow flag", v, 32'h2);
    wait_neg(1);
    rd(A_CNT, v);  check("R2 continues", v, 32'h101);
    wr(A_CTRL, 32'h0);

    // R3 one-shot
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    wait_neg(2);
    rd(A_CNT, v);  check("R3 wraps to zero", v, 0);
    rd(A_CTRL, v); check("R3 run cleared", v, 0);
    wait_neg(3);
    rd(A_CNT, v);  check("R3 stays stopped", v, 0);

    // R5/R6 compare with interrupt
    wr(A_STAT, 32'h7);
    wr(A_IEN, 32'h1);
    wr(A_CNT, 32'h0);
    wr(A_MATCH, 32'd5);
    wr(A_CTRL, 32'h41);
    wait_neg(4);
    rd(A_STAT, v); check("R5 no match yet", v, 0);
    check("R6 irq low before", 32'(irq), 0);
    wait_neg(1);
    rd(A_STAT, v); check("R5 match flag", v, 1);
    check("R6 irq on match", 32'(irq), 1);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R6 w1c clears", v, 0);
    check("R6 irq drops", 32'(irq), 0);

    // R5 compare disabled
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h1);
    wait_neg(8);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); check("R5 compare off", v, 0);

    // R6 masking and selective clear
    wr(A_IEN, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFC);
    wr(A_MATCH, 32'hFFFF_FFFD);
    wr(A_CTRL, 32'h43);
    wait_neg(4);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); check("R6 two flags", v, 32'h3);
    check("R6 irq masked", 32'(irq), 0);
    wr(A_IEN, 32'h2);
    check("R6 irq enabled", 32'(irq), 1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R6 selective clear", v, 32'h1);
    check("R6 irq after clear", 32'(irq), 0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R6 zero write keeps", v, 32'h1);
    wr(A_STAT, 32'h7);
    wr(A_IEN, 32'h0);

    // R8 capture edges, counter frozen
    wr(A_CNT, 32'hABCD);
    wr(A_CTRL, 32'h1 << 8);
    @(negedge clk); cap_in = 1'b1; wait_neg(4);
    rd(A_CAPT, v); check("R8 rising capture", v, 32'hABCD);
    rd(A_STAT, v); check("R8 capture flag", v, 32'h4);
    wr(A_STAT, 32'h4);
    @(negedge clk); cap_in = 1'b0; wait_neg(4);
    rd(A_STAT, v); check("R8 falling ignored", v, 0);
    wr(A_CNT, 32'h55);
    wr(A_CTRL, 32'h2 << 8);
    @(negedge clk); cap_in = 1'b1; wait_neg(4);
    rd(A_STAT, v); check("R8 rising ignored", v, 0);
    rd(A_CAPT, v); check("R8 capt unchanged", v, 32'hABCD);
    @(negedge clk); cap_in = 1'b0; wait_neg(4);
    rd(A_CAPT, v); check("R8 falling capture", v, 32'h55);
    rd(A_STAT, v); check("R8 falling flag", v, 32'h4);
    wr(A_STAT, 32'h4);
    wr(A_CNT, 32'h77);
    wr(A_CTRL, 32'h3 << 8);
    @(negedge clk); cap_in = 1'b1; wait_neg(4);
    rd(A_CAPT, v); check("R8 both rising", v, 32'h77);
    wr(A_CNT, 32'h88);
    @(negedge clk); cap_in = 1'b0; wait_neg(4);
    rd(A_CAPT, v); check("R8 both falling", v, 32'h88);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h4);
    wr(A_CNT, 32'h99);
    @(negedge clk); cap_in = 1'b1; wait_neg(4);
    @(negedge clk); cap_in = 1'b0; wait_neg(4);
    rd(A_STAT, v); check("R8 mode off flag", v, 0);
    rd(A_CAPT, v); check("R8 mode off capt", v, 32'h88);
    wr(A_CAPT, 32'h1111);
    rd(A_CAPT, v); check("R8 capture read-only", v, 32'h88);

    // R9/R10 PWM waveforms
    pwm_case(1'b0, 1'b0, 2'd1, "R10 pulse ovf def0");
    pwm_case(1'b1, 1'b0, 2'd1, "R10 pulse ovf def1");
    pwm_case(1'b0, 1'b1, 2'd1, "R10 toggle ovf");
    pwm_case(1'b0, 1'b0, 2'd2, "R9 pulse ovf+match");
    pwm_case(1'b1, 1'b1, 2'd2, "R9 toggle ovf+match");
    pwm_case(1'b1, 1'b0, 2'd0, "R9 trigger none");
    pwm_case(1'b0, 1'b1, 2'd3, "R9 trigger reserved");
    check("R10 idle after stop", 32'(pwm_out), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule